// File: doc/BRIEF.md
# Colour Palette Loader

This block holds a 256-entry colour lookup table with 8-bit red, green and blue channels. Software loads it through a small register window. One register selects the entry to load. A second register takes the three colour components one write at a time, red first, then green, then blue. Both registers take their byte from the most significant byte of the bus word.

A separate combinational lookup port returns the 24-bit colour of any entry. A scanout engine drives it with an 8-bit pixel code. Reads through the bus window always return zero, so software cannot read the table back. Reset clears every entry to black, except the last entry, which becomes white.

Top module: `pal_dac`

## Requirements
- R1: After reset every entry reads 0x000000 on the lookup port, except entry 255, which reads 0xFFFFFF. The selected entry clears to 0 and the component phase returns to red.
- R2: A write to register 0 (bits 3:2 of the address equal 0) loads the selected entry from write-data bits 31:24 and returns the component phase to red.
- R3: Successive writes to register 1 (bits 3:2 of the address equal 1) store write-data bits 31:24 into the red, green and blue channels of the selected entry, in that order, one channel per write. The lookup output is {red[23:16], green[15:8], blue[7:0]}.
- R4: After the blue write the phase returns to red and the selected entry stays unchanged, so a further three writes overwrite the same entry.
- R5: A register 0 write in the middle of a sequence restarts it, and the next register 1 write lands in the red channel.
- R6: Only address bits 3:2 select the register. Writes to registers 2 and 3 change neither the table, the selected entry nor the phase. Address bits 1:0 and the bits above bit 3 are ignored.
- R7: Bus reads return 0 and do not advance the phase.
- R8: A write takes effect only in a cycle where both valid and write are high. It completes in that cycle, with no wait state.
- R9: The lookup port is combinational. A component written in a cycle appears on the port from the next cycle onward, and not in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address within the window |
| bus_wdata_i | input | DATA_W | Write data; the byte used is bits 31:24 |
| bus_rdata_o | output | DATA_W | Read data, always zero |
| lut_idx_i | input | 8 | Lookup entry |
| lut_rgb_o | output | 24 | Lookup colour {R,G,B} |

## Verification
A wrong phase value sends a component to the wrong channel. The bench sees this on the lookup port one cycle after the data write, as a byte in the wrong position of the 24-bit result. A wrong selected entry changes a different entry instead. The bench therefore checks the entries next to the target as well as the target itself. A phase that advances on a read, on an ignored register or on a lone strobe shows up at the next data write, which then lands in a later channel.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  localparam int unsigned NUM_COMP = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam logic [1:0] REG_SEL  = 2'd0;
  localparam logic [1:0] REG_COMP = 2'd1;
endpackage

// File: rtl/pal_dac_decode.sv
module pal_dac_decode #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_wr_o,
  output logic              comp_wr_o
);
  import pal_dac_pkg::*;

  logic [1:0] reg_num;
  logic       wr_en;
  logic       unused_addr;

  assign reg_num     = addr_i[3:2];
  assign wr_en       = valid_i & write_i;
  assign sel_wr_o    = wr_en & (reg_num == REG_SEL);
  assign comp_wr_o   = wr_en & (reg_num == REG_COMP);
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/pal_dac_seq.sv
module pal_dac_seq #(
  parameter int unsigned IDX_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sel_wr_i,
  input  logic                            comp_wr_i,
  input  logic [IDX_W-1:0]                idx_d_i,
  output logic [IDX_W-1:0]                idx_o,
  output logic [1:0]                      phase_o,
  output logic [pal_dac_pkg::NUM_COMP-1:0] ch_we_o
);
  import pal_dac_pkg::*;

  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (sel_wr_i) begin
      idx_q   <= idx_d_i;
      phase_q <= PH_RED;
    end else if (comp_wr_i) begin
      unique case (phase_q)
        PH_RED:  phase_q <= PH_GRN;
        PH_GRN:  phase_q <= PH_BLU;
        default: phase_q <= PH_RED;  // blue wraps; stray code recovers
      endcase
    end
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_we
    assign ch_we_o[c] = comp_wr_i & (phase_q == phase_e'(c));
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/pal_dac_chan.sv
module pal_dac_chan #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned COMP_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [COMP_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [COMP_W-1:0] rdata_o
);
  logic [COMP_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= (i == DEPTH - 1) ? '1 : '0;
      end
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pal_dac.sv
module pal_dac #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned COMP_W      = 8,
  parameter int unsigned NUM_ENTRIES = 256,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned RGB_W      = pal_dac_pkg::NUM_COMP * COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [IDX_W-1:0]  lut_idx_i,
  output logic [RGB_W-1:0]  lut_rgb_o
);
  import pal_dac_pkg::*;

  logic                sel_wr, comp_wr;
  logic [IDX_W-1:0]    idx_q;
  logic [1:0]          phase_q;
  logic [NUM_COMP-1:0] ch_we;
  logic [COMP_W-1:0]   ch_rd [NUM_COMP];
  logic                unused_wdata;

  pal_dac_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid_i   (bus_valid_i),
    .write_i   (bus_write_i),
    .addr_i    (bus_addr_i),
    .sel_wr_o  (sel_wr),
    .comp_wr_o (comp_wr)
  );

  pal_dac_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_wr_i  (sel_wr),
    .comp_wr_i (comp_wr),
    .idx_d_i   (bus_wdata_i[DATA_W-1 -: IDX_W]),
    .idx_o     (idx_q),
    .phase_o   (phase_q),
    .ch_we_o   (ch_we)
  );

  // channel 0 = red, placed in the top byte of the lookup result
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_chan
    pal_dac_chan #(.DEPTH(NUM_ENTRIES), .COMP_W(COMP_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ch_we[c]),
      .waddr_i (idx_q),
      .wdata_i (bus_wdata_i[DATA_W-1 -: COMP_W]),
      .raddr_i (lut_idx_i),
      .rdata_o (ch_rd[c])
    );
    assign lut_rgb_o[RGB_W-1-c*COMP_W -: COMP_W] = ch_rd[c];
  end

  assign bus_rdata_o  = '0;
  assign unused_wdata = ^bus_wdata_i;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        phase_q
);
  logic wr, sel_w, comp_w;
  assign wr     = bus_valid_i && bus_write_i;
  assign sel_w  = wr && (bus_addr_i[3:2] == 2'd0);
  assign comp_w = wr && (bus_addr_i[3:2] == 2'd1);

  p_phase_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);

  p_sel_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_w |=> (idx_q == $past(bus_wdata_i[DATA_W-1 -: IDX_W])) && (phase_q == 2'd0));

  p_phase_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_w && phase_q < 2'd2) |=> phase_q == $past(phase_q) + 2'd1);

  p_phase_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_w && phase_q == 2'd2) |=> (phase_q == 2'd0) && $stable(idx_q));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(idx_q) && $stable(phase_q));

  p_other_reg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i[3]) |=> $stable(idx_q) && $stable(phase_q));
endmodule

bind pal_dac pal_dac_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .idx_q       (idx_q),
  .phase_q     (phase_q)
);

// File: tb/tb_pal_dac.sv
`timescale 1ns/1ps
module tb_pal_dac;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [7:0]  lut_idx_i = '0;
  logic [23:0] lut_rgb_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pal_dac dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_rgb(input logic [7:0] i, input logic [23:0] exp, input string req);
    lut_idx_i = i;
    #1;
    chk(lut_rgb_o === exp, req, {8'h0, lut_rgb_o}, {8'h0, exp});
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    expect_rgb(8'h00, 24'h000000, "R1 entry 0");
    expect_rgb(8'h11, 24'h000000, "R1 entry 11");
    expect_rgb(8'hFE, 24'h000000, "R1 entry fe");
    expect_rgb(8'hFF, 24'hFFFFFF, "R1 entry ff");
  endtask

  task automatic t_triple();
    bus_wr(12'h000, 32'h10_00_00_00);                     // R2 select 0x10
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = 12'h004; bus_wdata_i = 32'hAA_12_34_56;
    expect_rgb(8'h10, 24'h000000, "R9 not visible in write cycle");
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
    expect_rgb(8'h10, 24'hAA0000, "R9 visible next cycle / R3 red");
    bus_wr(12'h004, 32'hBB_FF_FF_FF);
    expect_rgb(8'h10, 24'hAABB00, "R3 green");
    bus_wr(12'h004, 32'hCC_00_00_01);
    expect_rgb(8'h10, 24'hAABBCC, "R3 blue");
    expect_rgb(8'h0F, 24'h000000, "R2 neighbour below");
    expect_rgb(8'h11, 24'h000000, "R2 neighbour above");
  endtask

  task automatic t_overwrite();
    bus_wr(12'h004, 32'h11_00_00_00);
    bus_wr(12'h004, 32'h22_00_00_00);
    bus_wr(12'h004, 32'h33_00_00_00);
    expect_rgb(8'h10, 24'h112233, "R4 second triple same entry");
    expect_rgb(8'h11, 24'h000000, "R4 index not advanced");
  endtask

  task automatic t_restart();
    bus_wr(12'h000, 32'h20_00_00_00);
    bus_wr(12'h004, 32'h44_00_00_00);
    bus_wr(12'h000, 32'h20_00_00_00);
    bus_wr(12'h004, 32'h55_00_00_00);
    expect_rgb(8'h20, 24'h550000, "R5 restart at red");
    bus_wr(12'h004, 32'h66_00_00_00);
    bus_wr(12'h004, 32'h77_00_00_00);
    expect_rgb(8'h20, 24'h556677, "R5 full triple after restart");
  endtask

  task automatic t_ignored();
    bus_wr(12'h000, 32'h30_00_00_00);
    bus_wr(12'h008, 32'h99_00_00_00);                     // register 2
    bus_wr(12'h00C, 32'h98_00_00_00);                     // register 3
    expect_rgb(8'h99, 24'h000000, "R6 reg2/3 no index load");
    bus_wr(12'h004, 32'h12_00_00_00);
    expect_rgb(8'h30, 24'h120000, "R6 reg2/3 no phase step");
    bus_wr(12'h105, 32'h34_00_00_00);                     // aliases register 1
    expect_rgb(8'h30, 24'h123400, "R6 upper/low address bits ignored");
    bus_wr(12'h0F1, 32'h40_00_00_00);                     // aliases register 0
    bus_wr(12'h004, 32'h56_00_00_00);
    expect_rgb(8'h40, 24'h560000, "R6 register 0 alias");
    expect_rgb(8'h30, 24'h123400, "R6 old entry kept");
  endtask

  task automatic t_read();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = 12'(k * 4); bus_wdata_i = 32'hFFFF_FFFF;
      #1;
      chk(bus_rdata_o === 32'h0, "R7 read returns zero", bus_rdata_o, 32'h0);
    end
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_wdata_i = '0;
    bus_wr(12'h004, 32'h78_00_00_00);
    expect_rgb(8'h40, 24'h567800, "R7 reads do not step phase");
  endtask

  task automatic t_strobe();
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_write_i = 1'b1; bus_addr_i = 12'h004; bus_wdata_i = 32'hEE_00_00_00;
    @(negedge clk_i);
    bus_addr_i = 12'h000; bus_wdata_i = 32'h00_00_00_00;
    @(negedge clk_i);
    bus_write_i = 1'b0;
    expect_rgb(8'h40, 24'h567800, "R8 write without valid ignored");
    bus_wr(12'h004, 32'h9A_00_00_00);
    expect_rgb(8'h40, 24'h56789A, "R8 single-cycle accepted write");
  endtask

  task automatic t_reset_again();
    do_reset();
    expect_rgb(8'h40, 24'h000000, "R1 reset clears loaded entry");
    expect_rgb(8'hFF, 24'hFFFFFF, "R1 reset restores white");
    bus_wr(12'h004, 32'h21_00_00_00);
    expect_rgb(8'h00, 24'h210000, "R1 index and phase cleared");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_triple();
    t_overwrite();
    t_restart();
    t_ignored();
    t_read();
    t_strobe();
    t_reset_again();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule